// File: doc/BRIEF.md
# Time-Multiplexed Three-Read Two-Write Register File

This block gives a target model a register file with three read ports and two write ports. The storage behind it is only single-read, single-write RAM. A target cycle begins with a one-clock start strobe. The block then spends three host clocks serving the three reads, one per clock, and commits the writes into the RAM. A one-clock done pulse tells the target model that the emulated cycle has finished. The next start may be given in that same done clock, so the block emulates one target cycle every three host clocks.

The storage is three synchronous RAM banks of DEPTH/3 entries each, selected by the upper part of the entry index. By default that is 768 entries of 64 bits, three 2 KB banks. Writes from a target cycle are held in registers and committed during the next target cycle. A bypass supplies them to reads of later target cycles, so no read ever sees a write from its own target cycle. One valid bit per entry makes unwritten entries read as zero without a clearing pass.

Top module: `tmrf_regfile`

## Requirements
- R1: After reset, busy and done are low, all three read data outputs are zero, and every entry reads back as zero until it is written.
- R2: A start sampled high while busy is low launches a target cycle. The read addresses, write enables, write addresses and write data are sampled only at that clock edge; later changes to them have no effect on that cycle.
- R3: After the launching edge, busy is high for exactly two clocks, then done is high for exactly one clock with busy low. A start in the done clock is accepted, which gives one target cycle per three host clocks.
- R4: A start sampled while busy is high is ignored. It changes neither the outputs of the running cycle nor the stored contents.
- R5: Each read port returns the entry as it stood before the writes of its own target cycle. It does include all writes of earlier target cycles, the immediately preceding one among them.
- R6: Both write ports take effect for later target cycles. When both are enabled to the same address, port 1's data is the value kept.
- R7: The three read outputs are valid in the done clock. They stay unchanged until the next accepted start edge.
- R8: Every address from 0 to DEPTH-1 is readable and writable on every port, including the entries on both sides of each bank boundary (DEPTH/3 and 2*DEPTH/3).
- R9: A write port whose enable is low at the start edge changes no entry, whatever its address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Target-cycle start strobe |
| busy | output | 1 | Target cycle in progress |
| done | output | 1 | One-clock pulse: target cycle complete |
| ra0 | input | AW | Read port 0 address |
| ra1 | input | AW | Read port 1 address |
| ra2 | input | AW | Read port 2 address |
| rd0 | output | WIDTH | Read port 0 data |
| rd1 | output | WIDTH | Read port 1 data |
| rd2 | output | WIDTH | Read port 2 data |
| we0 | input | 1 | Write port 0 enable |
| wa0 | input | AW | Write port 0 address |
| wd0 | input | WIDTH | Write port 0 data |
| we1 | input | 1 | Write port 1 enable |
| wa1 | input | AW | Write port 1 address |
| wd1 | input | WIDTH | Write port 1 data |

## Verification
Two things can fall in the same host clock: a read being issued to a bank, and the delayed commit of the previous target cycle's write to that same entry. The bench provokes this by reading, in the cycle right after a write, the address just written. It uses back-to-back cycles with both write ports colliding on one entry, and includes entries at the bank boundaries. Each read is judged against a flip-flop reference array that is updated only after the cycle's expected reads have been taken, with port 1 applied last.

// File: rtl/tmrf_regfile.sv
module tmrf_regfile #(
  parameter int DEPTH = 768,
  parameter int WIDTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             done,
  input  logic [AW-1:0]    ra0,
  input  logic [AW-1:0]    ra1,
  input  logic [AW-1:0]    ra2,
  output logic [WIDTH-1:0] rd0,
  output logic [WIDTH-1:0] rd1,
  output logic [WIDTH-1:0] rd2,
  input  logic             we0,
  input  logic [AW-1:0]    wa0,
  input  logic [WIDTH-1:0] wd0,
  input  logic             we1,
  input  logic [AW-1:0]    wa1,
  input  logic [WIDTH-1:0] wd1
);
  localparam int NBANK  = 3;
  localparam int BDEPTH = DEPTH / NBANK;
  localparam int BW     = $clog2(BDEPTH);
  localparam int SW     = $clog2(NBANK);

  function automatic logic [SW-1:0] bank_of(input logic [AW-1:0] a);
    return SW'(a / AW'(BDEPTH));
  endfunction

  function automatic logic [BW-1:0] off_of(input logic [AW-1:0] a);
    return BW'(a % AW'(BDEPTH));
  endfunction

  logic [1:0] ph_q;
  logic       done_q;
  wire        idle   = (ph_q == 2'd0);
  wire        accept = start && idle;

  logic [AW-1:0]    ra1_q, ra2_q;
  logic             cw0_en, cw1_en, pw0_en, pw1_en;
  logic [AW-1:0]    cw0_a, cw1_a, pw0_a, pw1_a;
  logic [WIDTH-1:0] cw0_d, cw1_d, pw0_d, pw1_d;

  wire          iss    = accept || !idle;
  wire [AW-1:0] iss_a  = idle ? ra0 : (ph_q == 2'd1 ? ra1_q : ra2_q);

  wire             cm_en = (ph_q == 2'd1 && pw0_en) || (ph_q == 2'd2 && pw1_en);
  wire [AW-1:0]    cm_a  = (ph_q == 2'd1) ? pw0_a : pw1_a;
  wire [WIDTH-1:0] cm_d  = (ph_q == 2'd1) ? pw0_d : pw1_d;

  logic [DEPTH-1:0] vld_q;
  logic [WIDTH-1:0] bq [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [WIDTH-1:0] mem [BDEPTH];
    logic [WIDTH-1:0] q;
    always_ff @(posedge clk) begin
      if (iss && bank_of(iss_a) == SW'(b)) q <= mem[off_of(iss_a)];
      if (cm_en && bank_of(cm_a) == SW'(b)) mem[off_of(cm_a)] <= cm_d;
    end
    assign bq[b] = q;
  end

  logic             h_byp, h_vld;
  logic [WIDTH-1:0] h_bd;
  logic [SW-1:0]    h_bank;
  logic [WIDTH-1:0] ram_sel, result;

  always_comb begin
    ram_sel = '0;
    for (int b = 0; b < NBANK; b++)
      if (h_bank == SW'(b)) ram_sel = bq[b];
  end

  assign result = h_byp ? h_bd : (h_vld ? ram_sel : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_byp  <= 1'b0;
      h_vld  <= 1'b0;
      h_bd   <= '0;
      h_bank <= '0;
    end else if (iss) begin
      h_bank <= bank_of(iss_a);
      h_vld  <= vld_q[iss_a];
      h_byp  <= (pw1_en && pw1_a == iss_a) || (pw0_en && pw0_a == iss_a);
      h_bd   <= (pw1_en && pw1_a == iss_a) ? pw1_d : pw0_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= '0;
    else if (cm_en) vld_q[cm_a] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= 2'd0;
      done_q <= 1'b0;
      rd0    <= '0;
      rd1    <= '0;
      ra1_q  <= '0;
      ra2_q  <= '0;
      cw0_en <= 1'b0;  cw0_a <= '0;  cw0_d <= '0;
      cw1_en <= 1'b0;  cw1_a <= '0;  cw1_d <= '0;
      pw0_en <= 1'b0;  pw0_a <= '0;  pw0_d <= '0;
      pw1_en <= 1'b0;  pw1_a <= '0;  pw1_d <= '0;
    end else begin
      done_q <= (ph_q == 2'd2);
      case (ph_q)
        2'd0: if (accept) begin
          ph_q   <= 2'd1;
          ra1_q  <= ra1;
          ra2_q  <= ra2;
          cw0_en <= we0;  cw0_a <= wa0;  cw0_d <= wd0;
          cw1_en <= we1;  cw1_a <= wa1;  cw1_d <= wd1;
        end
        2'd1: begin
          ph_q <= 2'd2;
          rd0  <= result;
        end
        default: begin
          ph_q   <= 2'd0;
          rd1    <= result;
          pw0_en <= cw0_en;  pw0_a <= cw0_a;  pw0_d <= cw0_d;
          pw1_en <= cw1_en;  pw1_a <= cw1_a;  pw1_d <= cw1_d;
        end
      endcase
    end
  end

  assign rd2  = result;
  assign busy = !idle;
  assign done = done_q;
endmodule

// File: rtl/tmrf_regfile_chk.sv
module tmrf_regfile_chk #(
  parameter int WIDTH = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] rd0,
  input logic [WIDTH-1:0] rd1,
  input logic [WIDTH-1:0] rd2
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (!busy && !done));

  assert_start_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_seq_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy ##1 (!busy && done));

  assert_busy_from_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(rd0) && $stable(rd1) && $stable(rd2)));
endmodule

bind tmrf_regfile tmrf_regfile_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .rd0(rd0), .rd1(rd1), .rd2(rd2)
);

// File: tb/tmrf_regfile_test.sv
module tmrf_regfile_test;
  localparam int DEPTH = 768;
  localparam int WIDTH = 64;
  localparam int AW    = 10;
  localparam int BD    = DEPTH / 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n, start, busy, done;
  logic [AW-1:0]    ra0, ra1, ra2, wa0, wa1;
  logic [WIDTH-1:0] rd0, rd1, rd2, wd0, wd1;
  logic             we0, we1;

  tmrf_regfile #(.DEPTH(DEPTH), .WIDTH(WIDTH)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .ra0(ra0), .ra1(ra1), .ra2(ra2), .rd0(rd0), .rd1(rd1), .rd2(rd2),
    .we0(we0), .wa0(wa0), .wd0(wd0), .we1(we1), .wa1(wa1), .wd1(wd1)
  );

  logic [WIDTH-1:0] ref_mem [DEPTH];
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic check(input string req, input string what,
                       input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] raddr();
    return AW'($urandom % DEPTH);
  endfunction

  function automatic logic [WIDTH-1:0] rdata();
    return {$urandom, $urandom};
  endfunction

  task automatic scramble();
    ra0 = raddr(); ra1 = raddr(); ra2 = raddr();
    we0 = 1'b1; wa0 = raddr(); wd0 = rdata();
    we1 = 1'b1; wa1 = raddr(); wd1 = rdata();
  endtask

  // Called at a negedge; returns at the negedge of the done clock.
  task automatic tcycle(input logic [AW-1:0] a0, a1, a2,
                        input logic e0, input logic [AW-1:0] x0, input logic [WIDTH-1:0] d0,
                        input logic e1, input logic [AW-1:0] x1, input logic [WIDTH-1:0] d1,
                        input string req, input bit noisy_start = 0);
    logic [WIDTH-1:0] x_0, x_1, x_2;
    x_0 = ref_mem[a0]; x_1 = ref_mem[a1]; x_2 = ref_mem[a2];
    ra0 = a0; ra1 = a1; ra2 = a2;
    we0 = e0; wa0 = x0; wd0 = d0;
    we1 = e1; wa1 = x1; wd1 = d1;
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = noisy_start;
    scramble();
    check("R3", "busy first clock", {63'd0, busy}, 64'd1);
    check("R3", "done first clock", {63'd0, done}, 64'd0);
    @(negedge clk);
    scramble();
    check("R3", "busy second clock", {63'd0, busy}, 64'd1);
    @(negedge clk);
    start = 1'b0;
    check("R3", "busy in done clock", {63'd0, busy}, 64'd0);
    check("R3", "done pulse", {63'd0, done}, 64'd1);
    check(req, "rd0", rd0, x_0);
    check(req, "rd1", rd1, x_1);
    check(req, "rd2", rd2, x_2);
    if (e0) ref_mem[x0] = d0;
    if (e1) ref_mem[x1] = d1;
    we0 = 1'b0; we1 = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; scramble(); we0 = 1'b0; we1 = 1'b0;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "busy after reset", {63'd0, busy}, 64'd0);
    check("R1", "done after reset", {63'd0, done}, 64'd0);
    check("R1", "rd0 after reset", rd0, '0);
    check("R1", "rd1 after reset", rd1, '0);
    check("R1", "rd2 after reset", rd2, '0);
  endtask

  task automatic t_unwritten();
    tcycle(10'd0, 10'd383, 10'd767, 0, 10'd0, '0, 0, 10'd0, '0, "R1 unwritten");
  endtask

  task automatic t_basic();
    tcycle(10'd5, 10'd6, 10'd300, 1, 10'd5, 64'h1111_2222_3333_4444,
           1, 10'd300, 64'hAAAA_BBBB_CCCC_DDDD, "R5 old data");
    tcycle(10'd300, 10'd5, 10'd7, 0, 10'd0, '0, 0, 10'd0, '0, "R6 both ports written");
  endtask

  task automatic t_collision();
    tcycle(10'd42, 10'd42, 10'd42, 1, 10'd42, 64'h0000_0000_0000_00F0,
           1, 10'd42, 64'h0000_0000_0000_00F1, "R5 same-cycle read");
    tcycle(10'd42, 10'd42, 10'd42, 1, 10'd42, 64'h5, 0, 10'd42, 64'h6, "R6 port1 wins");
    check("R6", "port1 value kept", rd0, 64'h0000_0000_0000_00F1);
  endtask

  task automatic t_disabled();
    tcycle(10'd100, 10'd101, 10'd102, 0, 10'd100, 64'hDEAD, 0, 10'd101, 64'hBEEF,
           "R9 disabled write");
    tcycle(10'd100, 10'd101, 10'd102, 0, 10'd0, '0, 0, 10'd0, '0, "R9 contents unchanged");
  endtask

  task automatic t_bank_edges();
    logic [AW-1:0] e [6] = '{10'(BD-1), 10'(BD), 10'(2*BD-1), 10'(2*BD), 10'(DEPTH-1), 10'd0};
    for (int i = 0; i < 6; i += 2)
      tcycle(e[i], e[i+1], e[5], 1, e[i], rdata(), 1, e[i+1], rdata(), "R8 boundary write");
    tcycle(e[0], e[1], e[2], 0, 10'd0, '0, 0, 10'd0, '0, "R8 boundary read");
    tcycle(e[3], e[4], e[5], 0, 10'd0, '0, 0, 10'd0, '0, "R8 boundary read");
  endtask

  task automatic t_ignored_start();
    logic [WIDTH-1:0] o0, o1, o2;
    tcycle(10'd200, 10'd201, 10'd202, 0, 10'd0, '0, 0, 10'd0, '0, "R4 running cycle", 1);
    o0 = rd0; o1 = rd1; o2 = rd2;
    idle(3);
    check("R4", "no relaunch busy", {63'd0, busy}, 64'd0);
    check("R4", "no relaunch done", {63'd0, done}, 64'd0);
    check("R7", "rd0 held", rd0, o0);
    check("R7", "rd1 held", rd1, o1);
    check("R7", "rd2 held", rd2, o2);
  endtask

  task automatic t_random(input int n);
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] a0, a1, a2, x0, x1;
      a0 = raddr(); x0 = raddr();
      x1 = ($urandom % 3 == 0) ? x0 : raddr();
      a1 = ($urandom % 2 == 0) ? x0 : raddr();
      a2 = ($urandom % 2 == 0) ? x1 : raddr();
      tcycle(a0, a1, a2, 1'($urandom), x0, rdata(), 1'($urandom), x1, rdata(),
             "R5 random");
      if ($urandom % 5 == 0) idle(1 + $urandom % 3);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_unwritten();
    t_basic();
    t_collision();
    t_disabled();
    t_bank_edges();
    t_ignored_start();
    t_random(400);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule